// File: doc/BRIEF.md
# Receive Frame Status Classifier

This block sits on the byte stream that leaves an Ethernet receive MAC and goes into the receive FIFO. It follows each frame from its start marker to its end marker and counts the bytes it accepts. At the end of the frame it builds a status word. The word holds the frame length and four error flags: oversize, undersize, stray trailing bits and checksum failure. Each byte is passed downstream one cycle late.

When trailer mode is on, the block adds three status bytes after the last data byte. It then gives a keep-or-discard verdict, which the FIFO writer uses to commit or roll back the frame. Damaged frames are always discarded in the strict filter mode. In the lenient mode, a damaged frame is kept if the address filter matched it.

A separate 8-bit counter records frames that the FIFO lost to overflow. The counter saturates at its maximum. A software read strobe clears it, and so can an interrupt-endpoint access when that clear option is enabled.

Top module: `rx_frame_status`

## Requirements
- R1: A byte is accepted when `in_valid` is high and it either carries `in_sof` or falls between a start and the next `in_eof`. Each accepted byte appears on `out_data` with `out_valid` one cycle later. Bytes with `in_valid` outside a frame are neither forwarded nor counted.
- R2: The length is the number of accepted bytes from the start byte through the end byte, both included, and saturates at 2^LEN_W-1. It is reported in `stat_word[LEN_W-1:0]`.
- R3: `stat_word[LEN_W+3]` (oversize) is set when the length exceeds 1518.
- R4: `stat_word[LEN_W+2]` (undersize) is set when the length is below 64.
- R5: `stat_word[LEN_W+1]` (stray bits) is set when `in_res_bits`, sampled with the end byte, is nonzero (1 to 7 leftover bits).
- R6: `stat_word[LEN_W]` (checksum) is set when `in_crc_ok` is low with the end byte.
- R7: With `cfg_append` high, three trailer bytes follow the last data byte, in this order: length bits 7:0, then length bits 15:8, then the flag byte {4'b0, oversize, undersize, stray bits, checksum}. `out_last` marks the third trailer byte. With `cfg_append` low, `out_last` marks the last data byte.
- R8: `stat_valid` is a one-cycle pulse that coincides with `out_last`. `stat_word` keeps the previous frame's value until the cycle after the end byte is accepted.
- R9: Together with `stat_valid`, exactly one of `frm_keep` and `frm_drop` pulses. A frame with no flag is kept. A flagged frame is dropped when `cfg_pass_bad` is low. When `cfg_pass_bad` is high, a flagged frame is kept only if `in_addr_hit` was high with its end byte.
- R10: Each cycle with `ovf_lost` high raises `lost_count` by one, up to 255, where it stays.
- R11: A `lost_rd` strobe clears `lost_count` on the next cycle. A lost frame that arrives in the same cycle leaves the count at 1.
- R12: An `ep_access` strobe clears `lost_count` as in R11 only while `cfg_ep_clr` is high. Otherwise it leaves the count unchanged.
- R13: After reset, `out_valid`, `out_last`, `stat_valid`, `frm_keep`, `frm_drop`, `stat_word` and `lost_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte qualifier |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Input byte |
| in_crc_ok | input | 1 | Checksum good, sampled with the end byte |
| in_res_bits | input | 3 | Leftover bit count, sampled with the end byte |
| in_addr_hit | input | 1 | Address filter matched, sampled with the end byte |
| cfg_append | input | 1 | Add the status trailer after the data |
| cfg_pass_bad | input | 1 | Lenient filter mode |
| cfg_ep_clr | input | 1 | Allow an endpoint access to clear the lost counter |
| ovf_lost | input | 1 | One frame lost to FIFO overflow |
| lost_rd | input | 1 | Software read strobe for the lost counter |
| ep_access | input | 1 | Interrupt-endpoint access strobe |
| out_valid | output | 1 | Output byte qualifier |
| out_data | output | 8 | Output byte (data or trailer) |
| out_last | output | 1 | Final output byte of the frame |
| stat_valid | output | 1 | Status strobe |
| stat_word | output | LEN_W+4 | Flags and length of the last completed frame |
| frm_keep | output | 1 | Commit the frame |
| frm_drop | output | 1 | Roll back the frame |
| lost_count | output | 8 | Frames lost to overflow |

## Verification
A wrong in-frame state or length register shows up at the ports in one of two ways: stray bytes are forwarded, or the length field at the next status strobe is off. Either appears within one frame. A trailer sequencer stuck in the wrong phase moves `out_last` or corrupts a trailer byte, and this is visible one to three cycles after the end byte. Errors in the lost counter surface on the cycle after the faulty update, because the bench compares `lost_count` on every clock. The saturation and conditional-clear cases are also checked directly.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int unsigned TRAILER_BYTES = 3;

  typedef struct packed {
    logic too_long;
    logic too_short;
    logic odd_bits;
    logic bad_crc;
  } rxs_flags_t;

  function automatic rxs_flags_t rxs_classify(
    input int unsigned len,
    input logic        crc_ok,
    input logic [2:0]  res_bits,
    input int unsigned min_len,
    input int unsigned max_len
  );
    rxs_flags_t f;
    f.too_long  = (len > max_len);
    f.too_short = (len < min_len);
    f.odd_bits  = (res_bits != 3'd0);
    f.bad_crc   = ~crc_ok;
    return f;
  endfunction

  function automatic logic [7:0] rxs_trailer_byte(
    input logic [1:0]  idx,
    input logic [15:0] len16,
    input rxs_flags_t  f
  );
    case (idx)
      2'd0:    return len16[7:0];
      2'd1:    return len16[15:8];
      default: return {4'b0000, f};
    endcase
  endfunction

endpackage

// File: rtl/rxs_len_track.sv
module rxs_len_track #(
  parameter int unsigned LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             byte_acc,
  output logic             frame_end,
  output logic [LEN_W-1:0] cur_len
);
  localparam logic [LEN_W-1:0] LEN_SAT = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  logic             in_frame_q;
  logic [LEN_W-1:0] cnt_q;

  assign byte_acc  = in_valid & (in_sof | in_frame_q);
  assign frame_end = byte_acc & in_eof;

  always_comb begin
    if (in_sof)                cur_len = LEN_ONE;
    else if (cnt_q == LEN_SAT) cur_len = cnt_q;
    else                       cur_len = cnt_q + LEN_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (byte_acc) begin
      cnt_q      <= cur_len;
      in_frame_q <= ~in_eof;
    end
  end
endmodule

// File: rtl/rxs_classifier.sv
module rxs_classifier
  import rxs_pkg::*;
#(
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic [LEN_W-1:0] cur_len,
  input  logic             crc_ok,
  input  logic [2:0]       res_bits,
  input  logic             addr_hit,
  input  logic             pass_bad,
  output rxs_flags_t       flags_q,
  output logic [LEN_W-1:0] len_q,
  output logic             keep_q
);
  rxs_flags_t flags_n;
  logic       keep_n;

  always_comb begin
    flags_n = rxs_classify(32'(cur_len), crc_ok, res_bits, MIN_LEN, MAX_LEN);
    keep_n  = ~(|flags_n) | (pass_bad & addr_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      len_q   <= '0;
      keep_q  <= 1'b0;
    end else if (frame_end) begin
      flags_q <= flags_n;
      len_q   <= cur_len;
      keep_q  <= keep_n;
    end
  end
endmodule

// File: rtl/rxs_emitter.sv
module rxs_emitter
  import rxs_pkg::*;
#(
  parameter int unsigned LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_acc,
  input  logic             frame_end,
  input  logic [7:0]       in_data,
  input  logic             append_en,
  input  logic [LEN_W-1:0] len_q,
  input  rxs_flags_t       flags_q,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last
);
  localparam logic [1:0] LAST_IDX = 2'(TRAILER_BYTES - 1);

  logic       tact_q;
  logic [1:0] tidx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      tact_q    <= 1'b0;
      tidx_q    <= '0;
    end else begin
      if (byte_acc) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
        out_last  <= frame_end & ~append_en;
      end else if (tact_q) begin
        out_valid <= 1'b1;
        out_data  <= rxs_trailer_byte(tidx_q, 16'(len_q), flags_q);
        out_last  <= (tidx_q == LAST_IDX);
        tidx_q    <= tidx_q + 2'd1;
        if (tidx_q == LAST_IDX) tact_q <= 1'b0;
      end else begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
      if (frame_end & append_en) begin
        tact_q <= 1'b1;
        tidx_q <= '0;
      end
    end
  end
endmodule

// File: rtl/rxs_lost_ctr.sv
module rxs_lost_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lost_evt,
  input  logic             clr_evt,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          count <= '0;
    else if (clr_evt)                    count <= CNT_W'(lost_evt);
    else if (lost_evt && count != CNT_SAT) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
  import rxs_pkg::*;
#(
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned LOST_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic              in_crc_ok,
  input  logic [2:0]        in_res_bits,
  input  logic              in_addr_hit,
  input  logic              cfg_append,
  input  logic              cfg_pass_bad,
  input  logic              cfg_ep_clr,
  input  logic              ovf_lost,
  input  logic              lost_rd,
  input  logic              ep_access,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              stat_valid,
  output logic [LEN_W+3:0]  stat_word,
  output logic              frm_keep,
  output logic              frm_drop,
  output logic [LOST_W-1:0] lost_count
);
  logic             byte_acc;
  logic             frame_end;
  logic [LEN_W-1:0] cur_len;
  rxs_flags_t       flags_q;
  logic [LEN_W-1:0] len_q;
  logic             keep_q;
  logic             clr_evt;

  rxs_len_track #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .byte_acc(byte_acc), .frame_end(frame_end),
    .cur_len(cur_len)
  );

  rxs_classifier #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_cls (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .cur_len(cur_len),
    .crc_ok(in_crc_ok), .res_bits(in_res_bits), .addr_hit(in_addr_hit),
    .pass_bad(cfg_pass_bad), .flags_q(flags_q), .len_q(len_q), .keep_q(keep_q)
  );

  rxs_emitter #(.LEN_W(LEN_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .byte_acc(byte_acc), .frame_end(frame_end),
    .in_data(in_data), .append_en(cfg_append), .len_q(len_q),
    .flags_q(flags_q), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last)
  );

  assign clr_evt = lost_rd | (ep_access & cfg_ep_clr);

  rxs_lost_ctr #(.CNT_W(LOST_W)) u_lost (
    .clk(clk), .rst_n(rst_n), .lost_evt(ovf_lost), .clr_evt(clr_evt),
    .count(lost_count)
  );

  assign stat_valid = out_last;
  assign stat_word  = {flags_q, len_q};
  assign frm_keep   = out_last & keep_q;
  assign frm_drop   = out_last & ~keep_q;
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker #(
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned LOST_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stat_valid,
  input logic              out_valid,
  input logic              out_last,
  input logic              frm_keep,
  input logic              frm_drop,
  input logic [LEN_W-1:0]  stat_len,
  input logic              stat_long,
  input logic              stat_short,
  input logic              frame_end,
  input logic              cfg_append,
  input logic [LOST_W-1:0] lost_count,
  input logic              clr_evt,
  input logic              ovf_lost
);
  localparam logic [LOST_W-1:0] SAT = {LOST_W{1'b1}};

  // R8: the status strobe only comes with the final output byte
  a_r8_status_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (out_valid && out_last));

  // R9: exactly one verdict accompanies each status strobe
  a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> ($countones({frm_keep, frm_drop}) == 1));

  // R9: no verdict without a status strobe
  a_r9_quiet_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_valid |-> (!frm_keep && !frm_drop));

  // R3: the oversize flag agrees with the reported length
  a_r3_long_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_long == (32'(stat_len) > MAX_LEN)));

  // R4: the undersize flag agrees with the reported length
  a_r4_short_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (stat_short == (32'(stat_len) < MIN_LEN)));

  // R7: without a trailer the frame closes one cycle after its end byte
  a_r7_plain_close: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !cfg_append) |=> out_last);

  // R10: a saturated counter stays saturated until cleared
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_count == SAT && !clr_evt) |=> (lost_count == SAT));

  // R10: the counter never falls without a clear
  a_r10_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_evt |=> (lost_count >= $past(lost_count)));

  // R11: a clear with no lost frame empties the counter
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !ovf_lost) |=> (lost_count == '0));
endmodule

bind rx_frame_status rxs_checker #(
  .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .LOST_W(LOST_W)
) u_rxs_chk (
  .clk(clk), .rst_n(rst_n), .stat_valid(stat_valid), .out_valid(out_valid),
  .out_last(out_last), .frm_keep(frm_keep), .frm_drop(frm_drop),
  .stat_len(stat_word[LEN_W-1:0]), .stat_long(stat_word[LEN_W+3]),
  .stat_short(stat_word[LEN_W+2]), .frame_end(frame_end),
  .cfg_append(cfg_append), .lost_count(lost_count), .clr_evt(clr_evt),
  .ovf_lost(ovf_lost)
);

// File: tb/tb_rx_frame_status.sv
`timescale 1ns/1ps
module tb_rx_frame_status;
  localparam int LEN_W = 14;
  localparam int LMAX  = (1 << LEN_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_crc_ok = 1, in_addr_hit = 0;
  logic [7:0] in_data = 0;
  logic [2:0] in_res_bits = 0;
  logic cfg_append = 0, cfg_pass_bad = 0, cfg_ep_clr = 0;
  logic ovf_lost = 0, lost_rd = 0, ep_access = 0;
  logic out_valid, out_last, stat_valid, frm_keep, frm_drop;
  logic [7:0] out_data;
  logic [LEN_W+3:0] stat_word;
  logic [7:0] lost_count;

  rx_frame_status dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .in_crc_ok(in_crc_ok),
    .in_res_bits(in_res_bits), .in_addr_hit(in_addr_hit),
    .cfg_append(cfg_append), .cfg_pass_bad(cfg_pass_bad),
    .cfg_ep_clr(cfg_ep_clr), .ovf_lost(ovf_lost), .lost_rd(lost_rd),
    .ep_access(ep_access), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .stat_valid(stat_valid), .stat_word(stat_word),
    .frm_keep(frm_keep), .frm_drop(frm_drop), .lost_count(lost_count)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural reference state
  int m_cnt = 0;
  bit m_inframe = 0;
  logic [7:0] tq[$];
  bit m_ev = 0, m_el = 0, m_keep = 0;
  logic [7:0] m_ed = 0;
  int m_len = 0;
  bit m_long = 0, m_short = 0, m_odd = 0, m_crc = 0;
  int m_lost = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    bit acc, clr;
    int nl;
    acc = in_valid && (in_sof || m_inframe);
    if (acc) begin
      nl = in_sof ? 1 : ((m_cnt + 1 > LMAX) ? LMAX : m_cnt + 1);
      m_cnt = nl;
      m_inframe = !in_eof;
      m_ev = 1; m_ed = in_data; m_el = in_eof && !cfg_append;
    end else if (tq.size() > 0) begin
      m_ev = 1; m_ed = tq.pop_front(); m_el = (tq.size() == 0);
    end else begin
      m_ev = 0; m_el = 0;
    end
    if (acc && in_eof) begin
      m_len = m_cnt;
      m_long = m_len > 1518; m_short = m_len < 64;
      m_odd = in_res_bits != 0; m_crc = !in_crc_ok;
      m_keep = !(m_long || m_short || m_odd || m_crc) || (cfg_pass_bad && in_addr_hit);
      if (cfg_append) begin
        tq.push_back(8'(m_len)); tq.push_back(8'(m_len >> 8));
        tq.push_back({4'b0, m_long, m_short, m_odd, m_crc});
      end
    end
    clr = lost_rd || (ep_access && cfg_ep_clr);
    if (clr) m_lost = ovf_lost ? 1 : 0;
    else if (ovf_lost && m_lost < 255) m_lost++;
    @(posedge clk); #1;
    chk(out_valid == m_ev, "R1", "out_valid", out_valid, m_ev);
    if (m_ev) chk(out_data == m_ed, "R7", "out_data", out_data, m_ed);
    chk(out_last == m_el, "R7", "out_last", out_last, m_el);
    chk(stat_valid == m_el, "R8", "stat_valid", stat_valid, m_el);
    chk(stat_word[LEN_W-1:0] == m_len, "R8", "held length", stat_word[LEN_W-1:0], m_len);
    if (m_el) begin
      chk(stat_word[LEN_W-1:0] == m_len, "R2", "length", stat_word[LEN_W-1:0], m_len);
      chk(stat_word[LEN_W+3] == m_long, "R3", "oversize", stat_word[LEN_W+3], m_long);
      chk(stat_word[LEN_W+2] == m_short, "R4", "undersize", stat_word[LEN_W+2], m_short);
      chk(stat_word[LEN_W+1] == m_odd, "R5", "stray bits", stat_word[LEN_W+1], m_odd);
      chk(stat_word[LEN_W] == m_crc, "R6", "checksum", stat_word[LEN_W], m_crc);
      chk(frm_keep == m_keep && frm_drop == !m_keep, "R9", "keep", frm_keep, m_keep);
    end else begin
      chk(!frm_keep && !frm_drop, "R9", "idle verdict", {frm_keep, frm_drop}, 0);
    end
    chk(lost_count == m_lost, "R10", "lost_count", lost_count, m_lost);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 0; in_sof = 0; in_eof = 0; ovf_lost = 0; lost_rd = 0; ep_access = 0;
      step();
    end
  endtask

  task automatic send(int n, bit crc_ok, int res, bit hit, int hole);
    in_crc_ok = crc_ok; in_res_bits = 3'(res); in_addr_hit = hit;
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1);
      in_data = 8'(i * 7 + n);
      step();
      if (hole > 0 && (i % hole) == hole - 1 && i != n - 1) begin
        in_valid = 0; in_sof = 0; in_eof = 0; step();
      end
    end
    idle(6);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #12; rst_n = 1; #1;
    // R13 reset state
    chk(!out_valid && !out_last && !stat_valid && !frm_keep && !frm_drop,
        "R13", "reset outputs", {out_valid, out_last, stat_valid, frm_keep, frm_drop}, 0);
    chk(stat_word == 0 && lost_count == 0, "R13", "reset word", stat_word, 0);
    idle(3);
    // plain mode, strict filter: length boundaries
    send(64, 1, 0, 0, 0);       // R4 boundary, kept
    send(63, 1, 0, 0, 0);       // R4 undersize, dropped
    send(1518, 1, 0, 0, 0);     // R3 boundary
    send(1519, 1, 0, 0, 0);     // R3 oversize
    send(1, 1, 0, 0, 0);        // single-byte frame
    // R1 stray bytes outside a frame
    for (int i = 0; i < 4; i++) begin
      in_valid = 1; in_sof = 0; in_eof = (i == 3); in_data = 8'hA5; step();
    end
    idle(3);
    // trailer mode with gaps in the stream
    cfg_append = 1;
    send(100, 0, 0, 1, 5);      // R6 checksum, strict: drop
    cfg_pass_bad = 1;
    send(100, 0, 0, 1, 3);      // R9 lenient with address hit: keep
    send(70, 0, 0, 0, 0);       // R9 lenient without hit: drop
    send(80, 1, 3, 0, 4);       // R5 stray bits
    send(300, 1, 0, 0, 0);      // R7 length high byte nonzero
    send(20, 1, 7, 1, 0);       // several flags, lenient hit
    cfg_append = 0; cfg_pass_bad = 0;
    // lost counter
    for (int i = 0; i < 3; i++) begin ovf_lost = 1; step(); end
    ovf_lost = 0; step();
    chk(lost_count == 3, "R10", "three lost", lost_count, 3);
    lost_rd = 1; ovf_lost = 1; step();
    lost_rd = 0; ovf_lost = 0;
    chk(lost_count == 1, "R11", "read with lost", lost_count, 1);
    ovf_lost = 1; step(); ovf_lost = 0;
    cfg_ep_clr = 0; ep_access = 1; step(); ep_access = 0;
    chk(lost_count == 2, "R12", "endpoint clear disabled", lost_count, 2);
    cfg_ep_clr = 1; ep_access = 1; step(); ep_access = 0; step();
    chk(lost_count == 0, "R12", "endpoint clear enabled", lost_count, 0);
    for (int i = 0; i < 260; i++) begin ovf_lost = 1; step(); end
    ovf_lost = 0; step();
    chk(lost_count == 255, "R10", "saturation", lost_count, 255);
    lost_rd = 1; step(); lost_rd = 0; step();
    chk(lost_count == 0, "R11", "read clear", lost_count, 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule